// File: doc/BRIEF.md
# Core Startup Message Sequencer

This block tracks the startup role of one processor core in a multi-core system and decides where that core first begins fetching instructions. It sits between an interprocessor message decoder and the core's fetch unit. The decoder hands it one-cycle strobes for a final-initialization broadcast, a vectored startup message, INIT, NMI and SMI. The core itself raises a halt request once its own init routine is done.

The bootstrap core waits for the final-initialization broadcast and then starts fetching at the top-of-memory reset address. Every other core ignores that broadcast and waits for a startup message. The 8-bit vector in that message picks a 4 KiB-aligned start page. A halted core wakes only on INIT, NMI or SMI. NMI and SMI restart it at a handler base address supplied from outside. INIT sends a core back to the waiting state that matches its role. Every fetch start is given as a one-cycle pulse together with an address that holds its value until the next pulse.

Top module: `core_start_seq`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0 (select), `fetch_go` is 0 and `fetch_addr` is 0.
- R2: On the first clock after reset release the block samples `boot_role` and keeps it as its role. It then enters state 1 (bootstrap idle) if the role is set, or state 2 (wait for startup) if it is clear.
- R3: In state 1 a final-init strobe moves the block to state 3 (run), pulses `fetch_go` and sets `fetch_addr` to 0xFFFF_FFF0. All three appear on the clock edge that samples the strobe.
- R4: A core in state 2 ignores the final-init strobe. It stays in state 2 with no pulse.
- R5: In state 2 a startup strobe moves the block to state 3 and pulses `fetch_go`. It sets `fetch_addr` to the vector shifted left by 12 bits, with zeros in every other bit (vector 0xA5 gives 0x000A_5000).
- R6: A startup strobe received in any state other than 2 changes neither the state nor the outputs.
- R7: In state 3 a halt request moves the block to state 4 (halted) without a pulse.
- R8: In state 4 an NMI or SMI strobe moves the block to state 3, pulses `fetch_go` and loads `fetch_addr` from `handler_base`. Outside state 4 these strobes have no effect.
- R9: In state 4 the startup, final-init and halt-request inputs have no effect.
- R10: INIT in any state, including when it arrives together with other strobes, sends the block to state 1 if its role is set and to state 2 otherwise, without a pulse.
- R11: `fetch_go` is never high for two cycles in a row, and it is high only in state 3. `fetch_addr` changes only in a cycle where `fetch_go` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_role | input | 1 | Bootstrap-role flag from core selection, sampled after reset |
| msg_finit | input | 1 | Final-initialization broadcast strobe |
| msg_start | input | 1 | Vectored startup message strobe |
| start_vec | input | 8 | Vector carried by the startup message |
| msg_init | input | 1 | INIT message strobe |
| msg_nmi | input | 1 | NMI message strobe |
| msg_smi | input | 1 | SMI message strobe |
| halt_req | input | 1 | Halt request from the core |
| handler_base | input | 32 | Restart address used when waking on NMI or SMI |
| fetch_go | output | 1 | One-cycle fetch-start pulse |
| fetch_addr | output | 32 | Start address, held between pulses |
| state_o | output | 3 | Current state code (0 select, 1 bootstrap idle, 2 wait startup, 3 run, 4 halted) |

## Verification
The fetch-start function is tried once from each of its three sources. The reset vector shows the bootstrap path. Two startup vectors (0xA5 and the all-ones 0xFF) show that the shift places every vector bit and clears the rest. Two different handler bases, one reached through NMI and one through SMI, show that the wake path loads the live input instead of a constant. Each strobe is also sent in states where it must be ignored, and INIT is sent together with NMI and the startup strobe. These cases separate a design that gates messages by state and role from one that only decodes the strobes. Running both roles from reset separates role sampling from role-independent behaviour.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [2:0] {
    ST_SELECT = 3'd0,
    ST_BOOT   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_RUN    = 3'd3,
    ST_HALT   = 3'd4
  } cs_state_t;

  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_RESET   = 2'd1,
    SRC_VECTOR  = 2'd2,
    SRC_HANDLER = 2'd3
  } cs_src_t;
endpackage

// File: rtl/cs_ctrl.sv
module cs_ctrl
  import cs_pkg::*;
(
  input  cs_state_t cur,
  input  logic      role,
  input  logic      finit,
  input  logic      start,
  input  logic      init,
  input  logic      nmi,
  input  logic      smi,
  input  logic      halt,
  output cs_state_t nxt,
  output cs_src_t   src,
  output logic      evt_boot_go,
  output logic      evt_vec_go,
  output logic      evt_wake_go,
  output logic      evt_init
);
  // Role-qualified events; INIT overrides all of them.
  assign evt_init    = init;
  assign evt_boot_go = !init && (cur == ST_BOOT) && role && finit;
  assign evt_vec_go  = !init && (cur == ST_WAIT) && start;
  assign evt_wake_go = !init && (cur == ST_HALT) && (nmi || smi);

  function automatic cs_state_t home_state(input logic r);
    return r ? ST_BOOT : ST_WAIT;
  endfunction

  always_comb begin
    nxt = cur;
    src = SRC_NONE;
    if (evt_init) begin
      nxt = home_state(role);
    end else begin
      unique case (cur)
        ST_SELECT: nxt = home_state(role);
        ST_BOOT: if (evt_boot_go) begin
          nxt = ST_RUN;
          src = SRC_RESET;
        end
        ST_WAIT: if (evt_vec_go) begin
          nxt = ST_RUN;
          src = SRC_VECTOR;
        end
        ST_RUN: if (halt) nxt = ST_HALT;
        ST_HALT: if (evt_wake_go) begin
          nxt = ST_RUN;
          src = SRC_HANDLER;
        end
        default: nxt = ST_SELECT;
      endcase
    end
  end
endmodule

// File: rtl/cs_addr_sel.sv
module cs_addr_sel
  import cs_pkg::*;
#(
  parameter int          VEC_W      = 8,
  parameter int          ADDR_W     = 32,
  parameter int          PAGE_SHIFT = 12,
  parameter logic [31:0] RESET_VEC  = 32'hFFFF_FFF0
) (
  input  cs_src_t             src,
  input  logic [VEC_W-1:0]    vec,
  input  logic [ADDR_W-1:0]   handler,
  output logic [ADDR_W-1:0]   addr
);
  localparam int PAD_W = ADDR_W - VEC_W - PAGE_SHIFT;

  function automatic logic [ADDR_W-1:0] page_of(input logic [VEC_W-1:0] v);
    return {{PAD_W{1'b0}}, v, {PAGE_SHIFT{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] reset_addr();
    return RESET_VEC[ADDR_W-1:0];
  endfunction

  always_comb begin
    unique case (src)
      SRC_RESET:   addr = reset_addr();
      SRC_VECTOR:  addr = page_of(vec);
      SRC_HANDLER: addr = handler;
      default:     addr = '0;
    endcase
  end
endmodule

// File: rtl/core_start_seq.sv
module core_start_seq
  import cs_pkg::*;
#(
  parameter int          VEC_W      = 8,
  parameter int          ADDR_W     = 32,
  parameter int          PAGE_SHIFT = 12,
  parameter logic [31:0] RESET_VEC  = 32'hFFFF_FFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_role,
  input  logic              msg_finit,
  input  logic              msg_start,
  input  logic [VEC_W-1:0]  start_vec,
  input  logic              msg_init,
  input  logic              msg_nmi,
  input  logic              msg_smi,
  input  logic              halt_req,
  input  logic [ADDR_W-1:0] handler_base,
  output logic              fetch_go,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [2:0]        state_o
);
  cs_state_t         state_q, state_d;
  cs_src_t           src;
  logic              role_q, role_eff;
  logic              go_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              evt_boot_go, evt_vec_go, evt_wake_go, evt_init;

  // Role is taken from the pin only while selecting, then frozen.
  assign role_eff = (state_q == ST_SELECT) ? boot_role : role_q;

  cs_ctrl u_ctrl (
    .cur         (state_q),
    .role        (role_eff),
    .finit       (msg_finit),
    .start       (msg_start),
    .init        (msg_init),
    .nmi         (msg_nmi),
    .smi         (msg_smi),
    .halt        (halt_req),
    .nxt         (state_d),
    .src         (src),
    .evt_boot_go (evt_boot_go),
    .evt_vec_go  (evt_vec_go),
    .evt_wake_go (evt_wake_go),
    .evt_init    (evt_init)
  );

  cs_addr_sel #(
    .VEC_W      (VEC_W),
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .RESET_VEC  (RESET_VEC)
  ) u_addr (
    .src     (src),
    .vec     (start_vec),
    .handler (handler_base),
    .addr    (addr_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_SELECT;
      role_q  <= 1'b0;
      go_q    <= 1'b0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SELECT) role_q <= boot_role;
      go_q <= (src != SRC_NONE);
      if (src != SRC_NONE) addr_q <= addr_d;
    end
  end

  assign fetch_go   = go_q;
  assign fetch_addr = addr_q;
  assign state_o    = state_q;
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
  parameter int          VEC_W      = 8,
  parameter int          ADDR_W     = 32,
  parameter int          PAGE_SHIFT = 12,
  parameter logic [31:0] RESET_VEC  = 32'hFFFF_FFF0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_finit,
  input logic              msg_start,
  input logic [VEC_W-1:0]  start_vec,
  input logic              msg_init,
  input logic              msg_nmi,
  input logic              msg_smi,
  input logic              halt_req,
  input logic [ADDR_W-1:0] handler_base,
  input logic              fetch_go,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [2:0]        state_o,
  input logic              evt_boot_go,
  input logic              evt_vec_go,
  input logic              evt_wake_go
);
  localparam int PAD_W = ADDR_W - VEC_W - PAGE_SHIFT;

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |=> !fetch_go);

  assert_pulse_in_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |-> state_o == 3'd3);

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_go |-> $stable(fetch_addr));

  assert_one_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_boot_go, evt_vec_go, evt_wake_go}));

  assert_boot_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && msg_finit && !msg_init) |=>
      (fetch_go && fetch_addr == RESET_VEC[ADDR_W-1:0]));

  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && !msg_start && !msg_init) |=> (state_o == 3'd2 && !fetch_go));

  assert_vec_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && msg_start && !msg_init) |=>
      (fetch_go && fetch_addr == {{PAD_W{1'b0}}, $past(start_vec), {PAGE_SHIFT{1'b0}}}));

  assert_run_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && halt_req && !msg_init) |=> (state_o == 3'd4 && !fetch_go));

  assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && (msg_nmi || msg_smi) && !msg_init) |=>
      (fetch_go && fetch_addr == $past(handler_base)));

  assert_halt_deaf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && !msg_nmi && !msg_smi && !msg_init) |=> (state_o == 3'd4));

  assert_init_home_R10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_init |=> ((state_o == 3'd1 || state_o == 3'd2) && !fetch_go));
endmodule

bind core_start_seq cs_checker #(
  .VEC_W      (VEC_W),
  .ADDR_W     (ADDR_W),
  .PAGE_SHIFT (PAGE_SHIFT),
  .RESET_VEC  (RESET_VEC)
) u_cs_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .msg_finit    (msg_finit),
  .msg_start    (msg_start),
  .start_vec    (start_vec),
  .msg_init     (msg_init),
  .msg_nmi      (msg_nmi),
  .msg_smi      (msg_smi),
  .halt_req     (halt_req),
  .handler_base (handler_base),
  .fetch_go     (fetch_go),
  .fetch_addr   (fetch_addr),
  .state_o      (state_o),
  .evt_boot_go  (evt_boot_go),
  .evt_vec_go   (evt_vec_go),
  .evt_wake_go  (evt_wake_go)
);

// File: tb/tb_core_start_seq.sv
module tb_core_start_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_role = 1'b0;
  logic        msg_finit = 1'b0, msg_start = 1'b0, msg_init = 1'b0;
  logic        msg_nmi = 1'b0, msg_smi = 1'b0, halt_req = 1'b0;
  logic [7:0]  start_vec = 8'h00;
  logic [31:0] handler_base = 32'h0;
  logic        fetch_go;
  logic [31:0] fetch_addr;
  logic [2:0]  state_o;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // Behavioural reference
  int          m_state = 0;
  bit          m_role = 0;
  bit          m_go = 0;
  logic [31:0] m_addr = 32'h0;

  always #4 clk = ~clk;

  core_start_seq dut (
    .clk(clk), .rst_n(rst_n), .boot_role(boot_role),
    .msg_finit(msg_finit), .msg_start(msg_start), .start_vec(start_vec),
    .msg_init(msg_init), .msg_nmi(msg_nmi), .msg_smi(msg_smi),
    .halt_req(halt_req), .handler_base(handler_base),
    .fetch_go(fetch_go), .fetch_addr(fetch_addr), .state_o(state_o)
  );

  always @(posedge clk) begin
    bit r;
    int ns;
    if (!rst_n) begin
      m_state = 0; m_role = 0; m_go = 0; m_addr = 32'h0;
    end else begin
      r = (m_state == 0) ? boot_role : m_role;
      if (m_state == 0) m_role = boot_role;
      ns = m_state;
      m_go = 0;
      if (msg_init) ns = r ? 1 : 2;
      else if (m_state == 0) ns = r ? 1 : 2;
      else if (m_state == 1 && r && msg_finit) begin
        ns = 3; m_go = 1; m_addr = 32'hFFFF_FFF0;
      end else if (m_state == 2 && msg_start) begin
        ns = 3; m_go = 1; m_addr = 32'(start_vec) * 4096;
      end else if (m_state == 3 && halt_req) ns = 4;
      else if (m_state == 4 && (msg_nmi || msg_smi)) begin
        ns = 3; m_go = 1; m_addr = handler_base;
      end
      m_state = ns;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare();
    n_chk++;
    if (state_o !== 3'(m_state) || fetch_go !== m_go || fetch_addr !== m_addr) begin
      n_fail++;
      $display("FAIL %s actual st=%0d go=%0b a=%h expected st=%0d go=%0b a=%h",
               cur_req, state_o, fetch_go, fetch_addr, m_state, m_go, m_addr);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    compare();
    {msg_finit, msg_start, msg_init, msg_nmi, msg_smi, halt_req} = '0;
  endtask

  task automatic do_reset(input bit role);
    rst_n = 1'b0; boot_role = role;
    repeat (2) @(posedge clk);
    #1;
    // R1 reset values
    check("R1", {29'h0, state_o}, 32'd0);
    check("R1", {31'h0, fetch_go}, 32'd0);
    check("R1", fetch_addr, 32'h0);
    rst_n = 1'b1;
    cur_req = "R2";
    step();
    boot_role = ~role; // role must stay as sampled
    check("R2", {29'h0, state_o}, role ? 32'd1 : 32'd2);
  endtask

  initial begin
    #1;
    // ---- bootstrap core ----
    do_reset(1'b1);
    cur_req = "R6"; msg_start = 1; start_vec = 8'h12; step();
    check("R6", {29'h0, state_o}, 32'd1);
    cur_req = "R3"; msg_finit = 1; step();
    check("R3", {31'h0, fetch_go}, 32'd1);
    check("R3", fetch_addr, 32'hFFFF_FFF0);
    cur_req = "R11"; step();
    check("R11", {31'h0, fetch_go}, 32'd0);
    check("R11", fetch_addr, 32'hFFFF_FFF0);
    cur_req = "R8"; msg_nmi = 1; handler_base = 32'h1111_0000; step();
    check("R8", fetch_addr, 32'hFFFF_FFF0);
    cur_req = "R7"; halt_req = 1; step();
    check("R7", {29'h0, state_o}, 32'd4);
    cur_req = "R9"; msg_start = 1; msg_finit = 1; halt_req = 1; step();
    check("R9", {29'h0, state_o}, 32'd4);
    check("R9", {31'h0, fetch_go}, 32'd0);
    cur_req = "R8"; msg_nmi = 1; handler_base = 32'h0000_8000; step();
    check("R8", fetch_addr, 32'h0000_8000);
    check("R8", {31'h0, fetch_go}, 32'd1);
    cur_req = "R7"; halt_req = 1; step();
    cur_req = "R8"; msg_smi = 1; handler_base = 32'hA000_0040; step();
    check("R8", fetch_addr, 32'hA000_0040);
    cur_req = "R10"; msg_init = 1; step();
    check("R10", {29'h0, state_o}, 32'd1);
    check("R10", fetch_addr, 32'hA000_0040);
    // ---- non-bootstrap core ----
    do_reset(1'b0);
    cur_req = "R4"; msg_finit = 1; step();
    check("R4", {29'h0, state_o}, 32'd2);
    check("R4", {31'h0, fetch_go}, 32'd0);
    cur_req = "R8"; msg_nmi = 1; msg_smi = 1; step();
    check("R8", {29'h0, state_o}, 32'd2);
    cur_req = "R5"; msg_start = 1; start_vec = 8'hA5; step();
    check("R5", fetch_addr, 32'h000A_5000);
    check("R5", {31'h0, fetch_go}, 32'd1);
    cur_req = "R6"; msg_start = 1; start_vec = 8'h3C; step();
    check("R6", fetch_addr, 32'h000A_5000);
    cur_req = "R7"; halt_req = 1; step();
    cur_req = "R10"; msg_init = 1; msg_nmi = 1; msg_start = 1; step();
    check("R10", {29'h0, state_o}, 32'd2);
    check("R10", {31'h0, fetch_go}, 32'd0);
    cur_req = "R5"; msg_start = 1; start_vec = 8'hFF; step();
    check("R5", fetch_addr, 32'h000F_F000);
    cur_req = "R10"; msg_init = 1; msg_finit = 1; step();
    check("R10", {29'h0, state_o}, 32'd2);
    cur_req = "R5"; msg_start = 1; start_vec = 8'h00; step();
    check("R5", fetch_addr, 32'h0000_0000);
    step();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule